// File: doc/BRIEF.md
# Serial Shift Sequencer

This block performs logical left, logical right and arithmetic right shifts on a 32-bit operand in a one-bit-wide datapath, without a barrel shifter. The operand arrives one bit per cycle, LSB first, during a capture stage of 32 cycles. The shift amount arrives serially on a second input over the same cycles. The block then produces the shifted value one bit per cycle, LSB first, during a 32-cycle write-back stage.

The shift comes from timing alone. For a left shift the write-back stage starts at once, but the buffered operand is held back for as many cycles as the shift amount, so zeros fill the low result bits. For a right shift the buffer starts draining as soon as capture ends, and the write-back stage is held off for the shift amount. The bits that drain first are never written. Once the buffer has run out of valid bits, it supplies zero or the sign bit. The surrounding core holds the capture flag high and reads the result while the write-back flag is high.

Top module: `ser_shift_seq`

## Requirements
- R1: After reset, `wb_en_o`, `res_o` and `done_o` are all low, and they stay low until a capture stage completes.
- R2: While `init_i` is high for 32 consecutive cycles, operand bit k is taken from `data_i` in capture cycle k (k = 0 is the LSB). The shift amount is formed from `amt_i` in capture cycles 0 to 4, with the bit from cycle 0 as its LSB. Values on `amt_i` in capture cycles 5 to 31 have no effect.
- R3: With `right_i` low, `wb_en_o` rises in the cycle right after the last capture cycle, and the 32 result bits equal the operand shifted left by the amount.
- R4: With `right_i` high and `arith_i` low, `wb_en_o` rises exactly N cycles after the first cycle following capture, where N is the amount. The result equals the operand shifted right logically, with zero fill.
- R5: With `right_i` and `arith_i` both high, the vacated high result bits equal operand bit 31. With `right_i` low, `arith_i` has no effect.
- R6: Each write-back stage keeps `wb_en_o` high for exactly 32 consecutive cycles, and `res_o` is low whenever `wb_en_o` is low.
- R7: `done_o` is high for exactly one cycle per operation: the cycle that carries result bit 31.
- R8: A high `init_i` during the delay or write-back stage is ignored and does not alter the result in progress.
- R9: If `init_i` falls before 32 capture cycles, the capture is abandoned, no write-back stage follows, and the next full capture works normally.
- R10: A shift amount of 0 returns the operand unchanged for all three shift kinds, with no delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_i | input | 1 | Capture stage active |
| data_i | input | 1 | Serial operand bit, LSB first |
| amt_i | input | 1 | Serial shift amount bit, LSB first |
| right_i | input | 1 | 1 = shift right, 0 = shift left |
| arith_i | input | 1 | 1 = sign fill on right shifts |
| wb_en_o | output | 1 | Write-back stage active |
| res_o | output | 1 | Serial result bit, LSB first |
| done_o | output | 1 | Pulse with the last result bit |

## Verification
The assertions check the framing on every cycle. They check that each write-back window is exactly 32 cycles long, that `res_o` is quiet outside the window, and that `done_o` is a single pulse on the window's final cycle and is followed by an idle cycle. Only the bench scenarios can show that the bit values are right. These cover the left, logical right and arithmetic right results at amounts 0, 1, mid-range and 31, and the N-cycle start delay of right shifts. They also cover ignored upper amount bits, an `init_i` pulse in the middle of write-back, and recovery from an abandoned capture.

// File: rtl/ser_shift_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial shift sequencer.
package ser_shift_pkg;
    // Operation phases: idle, capture, right-shift pre-drain, write-back.
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_CAP   = 2'd1,
        SH_DELAY = 2'd2,
        SH_WRITE = 2'd3
    } sh_state_e;
endpackage

// File: rtl/ser_shift_ctr.sv
`timescale 1ns/1ps
// Stage bit counter: counts 0..DATA_W-1 while inc is high and wraps.
// Assumes DATA_W is a power of two. clr takes priority over inc.
module ser_shift_ctr #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    assign last = (cnt == CNT_W'(DATA_W - 1));

    // Advance the bit index, wrapping after the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= last ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/ser_shift_amt.sv
`timescale 1ns/1ps
// Shift amount register: assembles the amount from the first CNT_W
// serial bits of capture, then counts down to zero on request.
// Assumes cap_en and dec_en are never high in the same cycle.
module ser_shift_amt #(
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [CNT_W-1:0] cap_idx,
    input  logic             amt_bit,
    input  logic             dec_en,
    output logic             amt_zero,
    output logic             amt_one
);
    logic [CNT_W-1:0] amt_q;
    logic [CNT_W-1:0] amt_dec;

    assign amt_zero = (amt_q == '0);
    assign amt_one  = (amt_q == CNT_W'(1));
    assign amt_dec  = amt_q - 1'b1;

    // Load the indexed amount bit during capture, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amt_q <= '0;
        end else begin
            for (int b = 0; b < CNT_W; b++) begin
                if (cap_en && cap_idx == CNT_W'(b))
                    amt_q[b] <= amt_bit;
                else if (dec_en && !amt_zero)
                    amt_q[b] <= amt_dec[b];
            end
        end
    end
endmodule

// File: rtl/ser_shift_buf.sv
`timescale 1ns/1ps
// Operand buffer: fills from the top during capture, so the operand
// ends up LSB-aligned after DATA_W bits, then drains LSB first.
// The fill bit is the last captured bit (the MSB) gated by sign_fill.
module ser_shift_buf #(
    parameter int DATA_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic data_bit,
    input  logic sign_fill,
    input  logic shift_en,
    output logic lsb
);
    logic [DATA_W-1:0] buf_q;
    logic              fill_q;

    assign lsb = buf_q[0];

    // Capture new bits at the top, or drain with the fill value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            fill_q <= 1'b0;
        end else if (cap_en) begin
            buf_q  <= {data_bit, buf_q[DATA_W-1:1]};
            fill_q <= sign_fill & data_bit;
        end else if (shift_en) begin
            buf_q  <= {fill_q, buf_q[DATA_W-1:1]};
        end
    end
endmodule

// File: rtl/ser_shift_seq.sv
`timescale 1ns/1ps
// Serial shift sequencer top. Captures an operand and a shift amount
// serially over DATA_W cycles, then writes the shifted result serially
// over DATA_W cycles. Left shifts hold the buffer while the amount
// counts down; right shifts drain the buffer while the write-back stage
// is held off. Assumes init_i stays high for exactly DATA_W cycles and
// that right_i/arith_i are stable during capture.
module ser_shift_seq
    import ser_shift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic data_i,
    input  logic amt_i,
    input  logic right_i,
    input  logic arith_i,
    output logic wb_en_o,
    output logic res_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(DATA_W);

    sh_state_e        state_q, state_d;
    logic [CNT_W-1:0] bit_cnt;
    logic             cnt_last;
    logic             cap_en;
    logic             in_write;
    logic             in_delay;
    logic             amt_zero;
    logic             amt_one;
    logic             shift_en;
    logic             dec_en;
    logic             buf_lsb;

    assign in_write = (state_q == SH_WRITE);
    assign in_delay = (state_q == SH_DELAY);
    assign cap_en   = init_i && (state_q == SH_IDLE || state_q == SH_CAP);
    assign dec_en   = in_delay || (in_write && !amt_zero);
    assign shift_en = in_delay || (in_write && amt_zero);

    ser_shift_ctr #(.DATA_W(DATA_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!cap_en && !in_write),
        .inc   (cap_en || in_write),
        .cnt   (bit_cnt),
        .last  (cnt_last)
    );

    ser_shift_amt #(.DATA_W(DATA_W)) u_amt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_idx  (bit_cnt),
        .amt_bit  (amt_i),
        .dec_en   (dec_en),
        .amt_zero (amt_zero),
        .amt_one  (amt_one)
    );

    ser_shift_buf #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .data_bit  (data_i),
        .sign_fill (arith_i & right_i),
        .shift_en  (shift_en),
        .lsb       (buf_lsb)
    );

    // Select the next phase of the operation.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE:  if (init_i) state_d = SH_CAP;
            SH_CAP: begin
                if (!init_i)
                    state_d = SH_IDLE;
                else if (cnt_last)
                    state_d = (right_i && !amt_zero) ? SH_DELAY : SH_WRITE;
            end
            SH_DELAY: if (amt_one) state_d = SH_WRITE;
            SH_WRITE: if (cnt_last) state_d = SH_IDLE;
            default:  state_d = SH_IDLE;
        endcase
    end

    // Hold the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SH_IDLE;
        else
            state_q <= state_d;
    end

    assign wb_en_o = in_write;
    assign res_o   = in_write && amt_zero && buf_lsb;
    assign done_o  = in_write && cnt_last;
endmodule

// File: rtl/ser_shift_seq_chk.sv
`timescale 1ns/1ps
// Port-level checker for the serial shift sequencer: write-back window
// length, output quietness and completion pulse framing.
module ser_shift_seq_chk #(
    parameter int DATA_W = 32
) (
    input logic clk,
    input logic rst_n,
    input logic wb_en_o,
    input logic res_o,
    input logic done_o
);
    localparam int RUN_W = $clog2(DATA_W) + 2;

    logic [RUN_W-1:0] run_q;

    // Count consecutive write-back cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else
            run_q <= wb_en_o ? run_q + 1'b1 : '0;
    end

    p_wb_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wb_en_o) |-> run_q == RUN_W'(DATA_W));

    p_wb_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> run_q < RUN_W'(DATA_W));

    p_res_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en_o |-> !res_o);

    p_done_in_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (wb_en_o && run_q == RUN_W'(DATA_W - 1)));

    p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!wb_en_o && !done_o));
endmodule

bind ser_shift_seq ser_shift_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wb_en_o (wb_en_o),
    .res_o   (res_o),
    .done_o  (done_o)
);

// File: tb/ser_shift_seq_bench.sv
`timescale 1ns/1ps
module ser_shift_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_i = 1'b0, data_i = 1'b0, amt_i = 1'b0;
    logic right_i = 1'b0, arith_i = 1'b0;
    logic wb_en_o, res_o, done_o;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    ser_shift_seq #(.DATA_W(32)) u_ser_shift_seq (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .data_i(data_i),
        .amt_i(amt_i), .right_i(right_i), .arith_i(arith_i),
        .wb_en_o(wb_en_o), .res_o(res_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Full operation: capture, measure delay, collect and check 32 bits.
    task automatic run_shift(input logic [31:0] op, input logic [31:0] amt_word,
                             input logic right, input logic arith,
                             input bit poke_init, input string req);
        int n = int'(amt_word[4:0]);
        logic [31:0] exp, got;
        int d = 0, done_cnt = 0, done_at = -1, wb_gap = 0;
        if (!right) exp = op << n;
        else if (arith) exp = $unsigned($signed(op) >>> n);
        else exp = op >> n;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            init_i = 1'b1; data_i = op[k]; amt_i = amt_word[k];
            right_i = right; arith_i = arith;
        end
        @(negedge clk);
        init_i = 1'b0; data_i = 1'b0; amt_i = 1'b0;
        while (!wb_en_o && d < 40) begin
            @(posedge clk); @(negedge clk); d++;
        end
        chk(d == (right ? n : 0), req, "start delay", d, right ? n : 0);
        got = '0;
        for (int i = 0; i < 32; i++) begin
            if (poke_init && i == 10) begin init_i = 1'b1; data_i = 1'b1; amt_i = 1'b1; end
            if (poke_init && i == 20) begin init_i = 1'b0; data_i = 1'b0; amt_i = 1'b0; end
            got[i] = res_o;
            if (!wb_en_o) wb_gap++;
            if (done_o) begin done_cnt++; done_at = i; end
            @(posedge clk); @(negedge clk);
        end
        chk(got == exp, req, "result", got, exp);
        chk(wb_gap == 0, "R6", "write window gaps", wb_gap, 0);
        chk(done_cnt == 1 && done_at == 31, "R7", "done position", done_at, 31);
        chk(!wb_en_o && !res_o, "R6", "idle after window", {wb_en_o, res_o}, 0);
    endtask

    task automatic t_reset();
        chk(!wb_en_o && !res_o && !done_o, "R1", "outputs in reset",
            {wb_en_o, res_o, done_o}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!wb_en_o && !res_o && !done_o, "R1", "outputs after reset",
            {wb_en_o, res_o, done_o}, 0);
    endtask

    task automatic t_left();
        run_shift(32'hA5C3_0F71, 32'd0, 1'b0, 1'b0, 1'b0, "R10");
        run_shift(32'hA5C3_0F71, 32'd1, 1'b0, 1'b0, 1'b0, "R3");
        run_shift(32'h8123_4567, 32'd13, 1'b0, 1'b0, 1'b0, "R3");
        run_shift(32'hFFFF_FFFF, 32'd31, 1'b0, 1'b0, 1'b0, "R3");
        run_shift(32'h8000_00F1, 32'd4, 1'b0, 1'b1, 1'b0, "R5");
    endtask

    task automatic t_right();
        run_shift(32'h9ABC_DEF0, 32'd0, 1'b1, 1'b0, 1'b0, "R10");
        run_shift(32'h9ABC_DEF0, 32'd5, 1'b1, 1'b0, 1'b0, "R4");
        run_shift(32'hF000_0001, 32'd31, 1'b1, 1'b0, 1'b0, "R4");
        run_shift(32'h9ABC_DEF0, 32'd0, 1'b1, 1'b1, 1'b0, "R10");
    endtask

    task automatic t_arith();
        run_shift(32'h8765_4321, 32'd4, 1'b1, 1'b1, 1'b0, "R5");
        run_shift(32'h8000_0000, 32'd31, 1'b1, 1'b1, 1'b0, "R5");
        run_shift(32'h7654_3210, 32'd9, 1'b1, 1'b1, 1'b0, "R5");
    endtask

    task automatic t_upper_amt();
        run_shift(32'h1357_9BDF, 32'hFFFF_FFE3, 1'b0, 1'b0, 1'b0, "R2");
        run_shift(32'h1357_9BDF, 32'hAAAA_AA02, 1'b1, 1'b0, 1'b0, "R2");
    endtask

    task automatic t_init_poke();
        run_shift(32'hC0FF_EE11, 32'd7, 1'b0, 1'b0, 1'b1, "R8");
        run_shift(32'hC0FF_EE11, 32'd3, 1'b1, 1'b1, 1'b1, "R8");
    endtask

    task automatic t_abort();
        int seen = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            init_i = 1'b1; data_i = k[0]; amt_i = 1'b1; right_i = 1'b0;
        end
        @(negedge clk); init_i = 1'b0;
        for (int c = 0; c < 45; c++) begin
            if (wb_en_o || res_o || done_o) seen++;
            @(posedge clk); @(negedge clk);
        end
        chk(seen == 0, "R9", "activity after abandoned capture", seen, 0);
        run_shift(32'h0F0F_1234, 32'd6, 1'b0, 1'b0, 1'b0, "R9");
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_left();
        t_right();
        t_arith();
        t_upper_amt();
        t_init_poke();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule